// File: doc/BRIEF.md
# Transmit Lane Allocator with Credit Tracking

This block sits on the sending end of one physical link that carries several virtual lanes. It keeps, for every lane, an ownership bit (lane idle or held by a packet), a count of empty flit slots in that lane's receive buffer at the far end, and an optional per-packet priority field. A packet that routing has already sent to this link asks for a lane. It receives the lowest-numbered idle lane. If every lane is held, it waits until one is given back.

Each flit that leaves on a lane uses up one credit of that lane. Acknowledgements that come back name the lane whose receive buffer has gained a slot, and each one adds one credit. A flit marked as the packet's last gives its lane back. Sending on a lane that has no credits left is reported as an error, and the counter does not wrap.

Top module: `tx_lane_alloc`

## Requirements
- R1: After reset every lane is idle (`lane_idle` all ones), every credit counter holds TOTAL_BUFS/NUM_LANES (4 with the defaults), and `alloc_gnt` and `send_err` are 0.
- R2: If `alloc_req` is high at a clock edge and at least one lane is idle, `alloc_gnt` is high for one cycle after that edge. `alloc_lane` then names the lowest-numbered idle lane, and that lane's `lane_idle` bit reads 0.
- R3: If `alloc_req` is high while no lane is idle, no grant is issued. The request waits and is granted after the edge that follows a lane's release.
- R4: A `send_vld` on lane L that has nonzero credits lowers L's credit count by one after the edge. Counts of other lanes are not affected.
- R5: A `crd_vld` on lane L raises L's credit count by one. A count never goes above TOTAL_BUFS/NUM_LANES, and a return on a full lane leaves it unchanged.
- R6: A send and a credit return on the same lane in the same cycle leave that lane's count unchanged. On different lanes, both take effect.
- R7: A send on a lane whose count is 0 makes `send_err` high for one cycle after the edge, and the count stays 0.
- R8: A send with `send_last` high on a held lane makes that lane idle after the edge.
- R9: When PRIO_W > 0, a granted lane's field in `lane_prio` (bits [L*PRIO_W +: PRIO_W]) takes the `alloc_prio` value present at the grant edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | A routed packet requests a lane; held until granted |
| alloc_prio | input | max(PRIO_W,1) | Priority recorded with the packet; unused when PRIO_W is 0 |
| alloc_gnt | output | 1 | One-cycle grant pulse |
| alloc_lane | output | $clog2(NUM_LANES) | Lane granted |
| send_vld | input | 1 | A flit leaves on `send_lane` this cycle |
| send_lane | input | $clog2(NUM_LANES) | Lane of the departing flit |
| send_last | input | 1 | Departing flit ends its packet |
| crd_vld | input | 1 | An acknowledgement returns one slot |
| crd_lane | input | $clog2(NUM_LANES) | Lane named by the acknowledgement |
| send_err | output | 1 | One-cycle pulse: a flit was sent on a lane with no credit |
| lane_idle | output | NUM_LANES | Per-lane idle bits |
| lane_credits | output | NUM_LANES*CW | Per-lane credit counts, lane L at [L*CW +: CW] with CW=$clog2(depth+1) |
| lane_prio | output | NUM_LANES*max(PRIO_W,1) | Per-lane recorded priority |

## Verification
Allocation is tried in three situations: with all lanes idle, with some lanes held, and with every lane held. These show whether the grant follows the lowest-index rule and whether a stalled request stays blocked until the exact edge after a release. The credit counters are driven four ways: by sends alone, by returns alone (including returns on a full lane), by a send and a return in the same cycle on one lane and on two different lanes, and by a run of sends that empties a lane and then goes past empty. Together these separate decrement, saturation, cancellation and the underflow error from one another.

// File: rtl/vcl_pkg.sv
package vcl_pkg;
  typedef enum logic [1:0] {
    CR_HOLD = 2'd0,
    CR_DEC  = 2'd1,
    CR_INC  = 2'd2
  } cr_op_e;
endpackage

// File: rtl/lane_pick.sv
module lane_pick #(
  parameter int NL = 4,
  parameter int LW = 2
) (
  input  logic [NL-1:0] idle,
  output logic          any,
  output logic [LW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (idle[i]) idx = LW'(i);
    end
    any = |idle;
  end
endmodule

// File: rtl/lane_credit.sv
module lane_credit
  import vcl_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  cr_op_e        op,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(DEPTH);
    end else begin
      case (op)
        CR_DEC:  if (cnt != '0) cnt <= cnt - 1'b1;
        CR_INC:  if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R5: the count stays within the receive buffer depth
  a_r5_cap: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R4: a decrement with credit left lowers the count by one
  a_r4_dec: assert property (@(posedge clk) disable iff (rst)
    (op == CR_DEC && cnt != '0) |=> cnt == CW'($past(cnt) - 1'b1));
  // R7: an empty counter does not wrap
  a_r7_floor: assert property (@(posedge clk) disable iff (rst)
    (op == CR_DEC && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/tx_lane_alloc.sv
module tx_lane_alloc
  import vcl_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int TOTAL_BUFS = 16,
  parameter int PRIO_W     = 0,
  localparam int DEPTH = TOTAL_BUFS / NUM_LANES,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LW    = $clog2(NUM_LANES),
  localparam int PW    = (PRIO_W > 0) ? PRIO_W : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_req,
  input  logic [PW-1:0]           alloc_prio,
  output logic                    alloc_gnt,
  output logic [LW-1:0]           alloc_lane,
  input  logic                    send_vld,
  input  logic [LW-1:0]           send_lane,
  input  logic                    send_last,
  input  logic                    crd_vld,
  input  logic [LW-1:0]           crd_lane,
  output logic                    send_err,
  output logic [NUM_LANES-1:0]    lane_idle,
  output logic [NUM_LANES*CW-1:0] lane_credits,
  output logic [NUM_LANES*PW-1:0] lane_prio
);
  logic [NUM_LANES-1:0] idle_q;
  logic                 pick_any;
  logic [LW-1:0]        pick_idx;
  logic [CW-1:0]        cred [NUM_LANES];
  logic                 take;

  lane_pick #(.NL(NUM_LANES), .LW(LW)) u_pick (
    .idle (idle_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign take = alloc_req && pick_any;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic   dec, inc;
    cr_op_e op;
    assign dec = send_vld && (send_lane == LW'(g));
    assign inc = crd_vld && (crd_lane == LW'(g));
    assign op  = (dec && !inc) ? CR_DEC : ((inc && !dec) ? CR_INC : CR_HOLD);

    lane_credit #(.DEPTH(DEPTH), .CW(CW)) u_cred (
      .clk (clk),
      .rst (rst),
      .op  (op),
      .cnt (cred[g])
    );
    assign lane_credits[g*CW +: CW] = cred[g];

    if (PRIO_W > 0) begin : g_prio
      logic [PW-1:0] prio_q;
      always_ff @(posedge clk) begin
        if (rst) prio_q <= '0;
        else if (take && pick_idx == LW'(g)) prio_q <= alloc_prio;
      end
      assign lane_prio[g*PW +: PW] = prio_q;
    end else begin : g_noprio
      assign lane_prio[g*PW +: PW] = '0;
    end
  end

  if (PRIO_W == 0) begin : g_unused
    logic unused_prio;
    assign unused_prio = ^alloc_prio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q     <= '1;
      alloc_gnt  <= 1'b0;
      alloc_lane <= '0;
      send_err   <= 1'b0;
    end else begin
      alloc_gnt <= 1'b0;
      send_err  <= send_vld && (cred[send_lane] == '0);
      if (send_vld && send_last && !idle_q[send_lane])
        idle_q[send_lane] <= 1'b1;
      if (take) begin
        idle_q[pick_idx] <= 1'b0;
        alloc_gnt        <= 1'b1;
        alloc_lane       <= pick_idx;
      end
    end
  end

  assign lane_idle = idle_q;

  // R2: a granted lane is recorded as held
  a_r2_held: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |-> !idle_q[alloc_lane]);
  // R2: lane 0 idle means lane 0 is the one granted
  a_r2_lowest: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && idle_q[0]) |=> (alloc_gnt && alloc_lane == '0));
  // R3: nothing is granted while every lane is held
  a_r3_stall: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && idle_q == '0) |=> !alloc_gnt);
  // R8: the last flit frees its lane
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (send_vld && send_last && !idle_q[send_lane]) |=> idle_q[$past(send_lane)]);
endmodule

// File: tb/sim_tx_lane_alloc.sv
module sim_tx_lane_alloc;
  localparam int NL = 4, TB = 16, PRIO_W = 2;
  localparam int DEPTH = TB / NL, CW = $clog2(DEPTH + 1), LW = $clog2(NL);

  logic clk = 0, rst = 1;
  logic alloc_req = 0;
  logic [PRIO_W-1:0] alloc_prio = '0;
  logic alloc_gnt;
  logic [LW-1:0] alloc_lane;
  logic send_vld = 0, send_last = 0, crd_vld = 0;
  logic [LW-1:0] send_lane = '0, crd_lane = '0;
  logic send_err;
  logic [NL-1:0] lane_idle;
  logic [NL*CW-1:0] lane_credits;
  logic [NL*PRIO_W-1:0] lane_prio;

  int checks = 0, failures = 0;
  int exp_cred [NL];
  bit done = 0;

  always #4 clk = ~clk;

  tx_lane_alloc #(.NUM_LANES(NL), .TOTAL_BUFS(TB), .PRIO_W(PRIO_W)) u0 (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_prio(alloc_prio),
    .alloc_gnt(alloc_gnt), .alloc_lane(alloc_lane), .send_vld(send_vld),
    .send_lane(send_lane), .send_last(send_last), .crd_vld(crd_vld),
    .crd_lane(crd_lane), .send_err(send_err), .lane_idle(lane_idle),
    .lane_credits(lane_credits), .lane_prio(lane_prio));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cred_of(input int l);
    return int'(lane_credits[l*CW +: CW]);
  endfunction

  task automatic chk_creds(input string tag);
    for (int l = 0; l < NL; l++) chk(tag, cred_of(l), exp_cred[l]);
  endtask

  // one cycle of send and/or credit return, sampled after the edge
  task automatic step(input bit sv, input int sl, input bit last,
                      input bit cv, input int cl);
    @(negedge clk);
    send_vld = sv; send_lane = LW'(sl); send_last = last;
    crd_vld = cv; crd_lane = LW'(cl);
    @(negedge clk);
    send_vld = 0; send_last = 0; crd_vld = 0;
  endtask

  task automatic t_reset;
    chk("R1 idle", int'(lane_idle), (1 << NL) - 1);
    chk("R1 gnt", int'(alloc_gnt), 0);
    chk("R1 err", int'(send_err), 0);
    for (int l = 0; l < NL; l++) exp_cred[l] = DEPTH;
    chk_creds("R1 credits");
  endtask

  task automatic t_alloc_order;
    for (int k = 0; k < NL; k++) begin
      @(negedge clk);
      alloc_req = 1; alloc_prio = PRIO_W'(NL - 1 - k);
      @(negedge clk);
      chk("R2 gnt", int'(alloc_gnt), 1);
      chk("R2 lane", int'(alloc_lane), k);
      chk("R2 held", int'(lane_idle[k]), 0);
      chk("R9 prio", int'(lane_prio[k*PRIO_W +: PRIO_W]), NL - 1 - k);
      alloc_req = 0;
    end
  endtask

  task automatic t_credit;
    step(1, 1, 0, 0, 0); exp_cred[1]--;
    chk_creds("R4 send");
    step(0, 0, 0, 1, 1); exp_cred[1]++;
    chk_creds("R5 return");
    step(0, 0, 0, 1, 1);
    chk_creds("R5 cap");
  endtask

  task automatic t_same_cycle;
    step(1, 1, 0, 1, 1);
    chk_creds("R6 same lane");
    step(1, 0, 0, 0, 0); exp_cred[0]--;
    step(1, 1, 0, 1, 0); exp_cred[0]++; exp_cred[1]--;
    chk_creds("R6 two lanes");
    step(0, 0, 0, 1, 1); exp_cred[1]++;
  endtask

  task automatic t_zero;
    for (int k = 0; k < DEPTH; k++) begin
      step(1, 3, 0, 0, 0); exp_cred[3]--;
      chk("R7 no err yet", int'(send_err), 0);
    end
    chk("R4 drained", cred_of(3), 0);
    step(1, 3, 0, 0, 0);
    chk("R7 err", int'(send_err), 1);
    chk_creds("R7 floor");
    for (int k = 0; k < DEPTH; k++) begin
      step(0, 0, 0, 1, 3); exp_cred[3]++;
    end
    chk("R7 err clear", int'(send_err), 0);
    chk_creds("R5 refill");
  endtask

  task automatic t_stall;
    @(negedge clk);
    alloc_req = 1; alloc_prio = 2'd2;
    @(negedge clk);
    chk("R3 stall a", int'(alloc_gnt), 0);
    @(negedge clk);
    chk("R3 stall b", int'(alloc_gnt), 0);
    send_vld = 1; send_lane = 2'd2; send_last = 1;
    @(negedge clk);
    send_vld = 0; send_last = 0; exp_cred[2]--;
    chk("R8 freed", int'(lane_idle[2]), 1);
    chk("R3 not yet", int'(alloc_gnt), 0);
    @(negedge clk);
    chk("R3 gnt", int'(alloc_gnt), 1);
    chk("R3 lane", int'(alloc_lane), 2);
    chk("R9 prio", int'(lane_prio[2*PRIO_W +: PRIO_W]), 2);
    alloc_req = 0;
    chk_creds("R4 last flit");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_alloc_order();
    t_credit();
    t_same_cycle();
    t_zero();
    t_stall();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule